// File: doc/BRIEF.md
# Multi-Controller Signal/Wait Synchronizer

Several small instruction controllers each step through their own loop nest at the same time. This block sits between those controllers and the control path that follows them. Each controller hands it operations, one per lane. A repeat operation puts a control word on the lane for a given number of cycles. A wait operation holds a word on the lane until another controller releases that lane. Any controller can raise a signal request that names a target lane. The block decides, every cycle, which lanes are stalled, released or skipping. It then combines the words of all lanes into one merged control word by a bitwise OR.

A signal that reaches a lane while it is waiting releases it. A signal that reaches a lane that is not waiting is stored in a one-deep pending slot, and the next wait accepted on that lane is then skipped without stalling. When signals arrive faster than the lane can use them, the extra ones are dropped. Each drop is recorded in a sticky per-lane flag and in a saturating drop counter. These give a loop schedule whose signal and wait counts do not match a visible symptom, so the mismatch does not silently corrupt the schedule.

Top module: `ctrl_sync_merge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every lane is idle: op_ready_o is all ones, stall_o, release_o, skip_o and ovf_flag_o are zero, merged_word_o is zero and ovf_count_o is zero.
- R2: A repeat operation (op_is_wait_i low) accepted with count c drives its word onto its lane for c cycles, or 1 cycle when c is 0. op_ready_o for that lane is high only in the last of those cycles, so a following operation can be accepted with no gap.
- R3: A wait operation (op_is_wait_i high) accepted with no signal available drives its word and raises stall_o every cycle, with op_ready_o low, until a signal reaches the lane.
- R4: A signal that reaches a stalled lane releases it in the same cycle. release_o is high, the wait word is still driven that cycle, and op_ready_o is high. From the next edge the lane no longer drives the word unless a new operation was accepted.
- R5: A signal that reaches a lane that is not waiting is kept pending. The next wait operation accepted on that lane is skipped: skip_o is high in the accepting cycle, and in the following cycle the lane neither stalls nor drives the word.
- R6: Controller k requests a signal with sig_valid_i[k]. The target lane number sits in sig_target_i[k*IDX_W +: IDX_W], with IDX_W = 2 for four lanes. Requests from several controllers to different targets in one cycle are all honoured, and a controller may signal its own lane.
- R7: A signal is dropped when it is not used by a release or a skip and the lane's single pending slot is already taken. In that case, from the next cycle on, the target's bit of ovf_flag_o stays set until reset. ovf_count_o grows by the number of signals dropped, and stops at 2^ERR_W-1.
- R8: merged_word_o is the bitwise OR of the words of all lanes that are currently active. An idle lane adds nothing.
- R9: Within one cycle, the signals available to a lane are used in a fixed order: first to release a current wait, then to skip a wait accepted in that same cycle, then to fill the pending slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| op_valid_i | input | N_CTRL | Per lane: an operation is offered |
| op_is_wait_i | input | N_CTRL | Per lane: 1 = wait operation, 0 = repeat operation |
| op_word_i | input | N_CTRL*WORD_W | Per lane control word, lane k in [k*WORD_W +: WORD_W] |
| op_count_i | input | N_CTRL*CNT_W | Per lane repeat count, 0 treated as 1 |
| op_ready_o | output | N_CTRL | Per lane: an offered operation is taken this cycle |
| sig_valid_i | input | N_CTRL | Per controller signal request strobe |
| sig_target_i | input | N_CTRL*IDX_W | Per controller target lane number |
| stall_o | output | N_CTRL | Lane is held in a wait |
| release_o | output | N_CTRL | Lane's wait ends this cycle |
| skip_o | output | N_CTRL | Wait accepted this cycle is skipped |
| merged_word_o | output | WORD_W | OR of all active lane words |
| ovf_flag_o | output | N_CTRL | Sticky per-lane dropped-signal flag |
| ovf_count_o | output | ERR_W | Saturating count of dropped signals |

## Verification
The bench builds the block with four lanes, 16-bit words and 4-bit repeat counts. It sets ERR_W to 4, so the drop counter reaches its ceiling of 15 during the randomized phase and saturation is exercised along with the ordinary count. With four controllers, up to four signals can reach one lane in a single cycle. This covers every combination of release, skip, pending fill and multi-signal drop in R9 and R7. Repeat counts from 0 to 3 cover the zero-count rule and the handover in the last repeat cycle.

// File: rtl/ctrl_sync_pkg.sv
package ctrl_sync_pkg;

  // Kind of operation held by a lane
  typedef enum logic {
    OP_REPEAT = 1'b0,
    OP_WAIT   = 1'b1
  } op_kind_e;

  // Saturating addition used by the drop counter
  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned lim);
    int unsigned s;
    s = a + b;
    return (s > lim) ? lim : s;
  endfunction

endpackage

// File: rtl/csync_hit_router.sv
// Turns per-controller signal requests into a per-target hit count.
module csync_hit_router #(
  parameter int N_CTRL = 4,
  parameter int IDX_W  = 2,
  parameter int HIT_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CTRL-1:0]         sig_valid_i,
  input  logic [N_CTRL*IDX_W-1:0]   sig_target_i,
  output logic [N_CTRL*HIT_W-1:0]   hit_cnt_o
);

  // Number of valid requests that name lane 'lane'
  function automatic logic [HIT_W-1:0] count_hits(input logic [N_CTRL-1:0] v,
                                                  input logic [N_CTRL*IDX_W-1:0] tg,
                                                  input int unsigned lane);
    logic [HIT_W-1:0] c;
    c = '0;
    for (int k = 0; k < N_CTRL; k++) begin
      if (v[k] && (32'(tg[k*IDX_W +: IDX_W]) == lane)) c = c + 1'b1;
    end
    return c;
  endfunction

  for (genvar t = 0; t < N_CTRL; t++) begin : g_target
    assign hit_cnt_o[t*HIT_W +: HIT_W] = count_hits(sig_valid_i, sig_target_i, t);
  end

  // Requests whose target exists
  logic [N_CTRL-1:0] in_range;
  always_comb begin
    for (int k = 0; k < N_CTRL; k++) begin
      in_range[k] = 32'(sig_target_i[k*IDX_W +: IDX_W]) < 32'(N_CTRL);
    end
  end

  int unsigned hit_total;
  always_comb begin
    hit_total = 0;
    for (int t = 0; t < N_CTRL; t++) hit_total = hit_total + 32'(hit_cnt_o[t*HIT_W +: HIT_W]);
  end

  // R6: every in-range request lands on exactly one target
  p_hits_conserved_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(hit_total) == $countones(sig_valid_i & in_range));

endmodule

// File: rtl/csync_lane.sv
// One controller lane: repeat expansion, wait/stall, pending signal slot.
module csync_lane
  import ctrl_sync_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4,
  parameter int HIT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_is_wait_i,
  input  logic [WORD_W-1:0] op_word_i,
  input  logic [CNT_W-1:0]  op_count_i,
  input  logic [HIT_W-1:0]  hit_cnt_i,
  output logic              op_ready_o,
  output logic [WORD_W-1:0] word_o,
  output logic              stall_o,
  output logic              release_o,
  output logic              skip_o,
  output logic [HIT_W-1:0]  drop_o
);

  localparam int AV_W = HIT_W + 1;

  // A zero repeat count still yields one cycle
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  logic              active_q;
  op_kind_e          kind_q;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  rem_q;
  logic              pend_q;

  // Named internal events
  logic            waiting;
  logic [AV_W-1:0] avail;
  logic            rel_ev;
  logic [AV_W-1:0] after_rel;
  logic            repeat_last;
  logic            done_ev;
  logic            take_ev;
  logic            skip_ev;
  logic [AV_W-1:0] after_skip;
  logic            pend_d;

  always_comb begin
    waiting     = active_q && (kind_q == OP_WAIT);
    avail       = AV_W'(pend_q) + AV_W'(hit_cnt_i);
    // Order of use: release first, then skip, then pending slot (R9)
    rel_ev      = waiting && (avail != '0);
    after_rel   = avail - AV_W'(rel_ev);
    repeat_last = active_q && (kind_q == OP_REPEAT) && (rem_q == CNT_W'(1));
    done_ev     = rel_ev || repeat_last;
    op_ready_o  = !active_q || done_ev;
    take_ev     = op_valid_i && op_ready_o;
    skip_ev     = take_ev && op_is_wait_i && (after_rel != '0);
    after_skip  = after_rel - AV_W'(skip_ev);
    pend_d      = (after_skip != '0);
    drop_o      = (after_skip > AV_W'(1)) ? HIT_W'(after_skip - AV_W'(1)) : '0;
  end

  assign word_o    = active_q ? word_q : '0;
  assign stall_o   = waiting && !rel_ev;
  assign release_o = rel_ev;
  assign skip_o    = skip_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      kind_q   <= OP_REPEAT;
      word_q   <= '0;
      rem_q    <= '0;
      pend_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (take_ev && !skip_ev) begin
        active_q <= 1'b1;
        kind_q   <= op_is_wait_i ? OP_WAIT : OP_REPEAT;
        word_q   <= op_word_i;
        rem_q    <= eff_count(op_count_i);
      end else if (take_ev || done_ev) begin
        active_q <= 1'b0;
      end else if (active_q && (kind_q == OP_REPEAT)) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  // R2: a repeat that is not finishing keeps the same word next cycle
  p_repeat_word_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && (kind_q == OP_REPEAT) && !op_ready_o) |=> (word_o == $past(word_o)));

  // R3: a stalled lane is still waiting next cycle with the same word
  p_stall_keeps_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ((stall_o || release_o) && (word_o == $past(word_o))));

  // R4: a released lane with nothing offered goes idle
  p_release_leaves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_o && !op_valid_i) |=> !active_q);

  // R5: a skipped wait leaves the lane idle
  p_skip_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> !active_q);

  // R5: a lane holding a pending signal never stalls
  p_pend_blocks_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !stall_o);

endmodule

// File: rtl/csync_or_merge.sv
// Bitwise OR of all lane words.
module csync_or_merge #(
  parameter int N_CTRL = 4,
  parameter int WORD_W = 16
) (
  input  logic [N_CTRL*WORD_W-1:0] lane_words_i,
  output logic [WORD_W-1:0]        merged_o
);

  function automatic logic [WORD_W-1:0] or_fold(input logic [N_CTRL*WORD_W-1:0] w);
    logic [WORD_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < N_CTRL; k++) acc = acc | w[k*WORD_W +: WORD_W];
    return acc;
  endfunction

  assign merged_o = or_fold(lane_words_i);

endmodule

// File: rtl/ctrl_sync_merge.sv
// Signal/wait synchronizer and word merger for parallel loop controllers.
module ctrl_sync_merge
  import ctrl_sync_pkg::*;
#(
  parameter int N_CTRL = 4,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4,
  parameter int ERR_W  = 8
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic [N_CTRL-1:0]                             op_valid_i,
  input  logic [N_CTRL-1:0]                             op_is_wait_i,
  input  logic [N_CTRL*WORD_W-1:0]                      op_word_i,
  input  logic [N_CTRL*CNT_W-1:0]                       op_count_i,
  output logic [N_CTRL-1:0]                             op_ready_o,
  input  logic [N_CTRL-1:0]                             sig_valid_i,
  input  logic [N_CTRL*((N_CTRL>1)?$clog2(N_CTRL):1)-1:0] sig_target_i,
  output logic [N_CTRL-1:0]                             stall_o,
  output logic [N_CTRL-1:0]                             release_o,
  output logic [N_CTRL-1:0]                             skip_o,
  output logic [WORD_W-1:0]                             merged_word_o,
  output logic [N_CTRL-1:0]                             ovf_flag_o,
  output logic [ERR_W-1:0]                              ovf_count_o
);

  localparam int          IDX_W   = (N_CTRL > 1) ? $clog2(N_CTRL) : 1;
  localparam int          HIT_W   = $clog2(N_CTRL + 2);
  localparam int unsigned ERR_MAX = (32'd1 << ERR_W) - 32'd1;

  logic [N_CTRL*HIT_W-1:0]  hit_flat;
  logic [N_CTRL*HIT_W-1:0]  drop_flat;
  logic [N_CTRL*WORD_W-1:0] lane_words;

  csync_hit_router #(
    .N_CTRL (N_CTRL),
    .IDX_W  (IDX_W),
    .HIT_W  (HIT_W)
  ) u_router (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sig_valid_i  (sig_valid_i),
    .sig_target_i (sig_target_i),
    .hit_cnt_o    (hit_flat)
  );

  for (genvar i = 0; i < N_CTRL; i++) begin : g_lane
    csync_lane #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W),
      .HIT_W  (HIT_W)
    ) u_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .op_valid_i   (op_valid_i[i]),
      .op_is_wait_i (op_is_wait_i[i]),
      .op_word_i    (op_word_i[i*WORD_W +: WORD_W]),
      .op_count_i   (op_count_i[i*CNT_W +: CNT_W]),
      .hit_cnt_i    (hit_flat[i*HIT_W +: HIT_W]),
      .op_ready_o   (op_ready_o[i]),
      .word_o       (lane_words[i*WORD_W +: WORD_W]),
      .stall_o      (stall_o[i]),
      .release_o    (release_o[i]),
      .skip_o       (skip_o[i]),
      .drop_o       (drop_flat[i*HIT_W +: HIT_W])
    );
  end

  csync_or_merge #(
    .N_CTRL (N_CTRL),
    .WORD_W (WORD_W)
  ) u_merge (
    .lane_words_i (lane_words),
    .merged_o     (merged_word_o)
  );

  // Total signals dropped this cycle
  function automatic int unsigned drop_total(input logic [N_CTRL*HIT_W-1:0] d);
    int unsigned s;
    s = 0;
    for (int k = 0; k < N_CTRL; k++) s = s + 32'(d[k*HIT_W +: HIT_W]);
    return s;
  endfunction

  logic [N_CTRL-1:0] drop_any;
  always_comb begin
    for (int k = 0; k < N_CTRL; k++) drop_any[k] = (drop_flat[k*HIT_W +: HIT_W] != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_flag_o  <= '0;
      ovf_count_o <= '0;
    end else begin
      ovf_flag_o  <= ovf_flag_o | drop_any;
      ovf_count_o <= ERR_W'(sat_add(32'(ovf_count_o), drop_total(drop_flat), ERR_MAX));
    end
  end

  // R7: the drop counter never decreases
  p_ovf_count_mono_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ovf_count_o >= $past(ovf_count_o)));

  for (genvar i = 0; i < N_CTRL; i++) begin : g_chk
    // R7: a drop in a lane sets its flag, and the flag stays set
    p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_any[i] |=> ovf_flag_o[i]);
    p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_flag_o[i] |=> ovf_flag_o[i]);
    // R8: every lane's bits appear in the merged word
    p_merge_covers_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_words[i*WORD_W +: WORD_W] & ~merged_word_o) == '0);
  end

  // R8: no active word means a zero merged word
  p_merge_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_words == '0) |-> (merged_word_o == '0));

endmodule

// File: tb/ctrl_sync_merge_tb.sv
module ctrl_sync_merge_tb;

  localparam int N  = 4;
  localparam int W  = 16;
  localparam int CW = 4;
  localparam int EW = 4;
  localparam int IW = 2;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4ns clk = ~clk;

  logic [N-1:0]    op_valid, op_is_wait, sig_valid;
  logic [N*W-1:0]  op_word;
  logic [N*CW-1:0] op_count;
  logic [N*IW-1:0] sig_target;
  logic [N-1:0]    op_ready, stall, release_s, skip;
  logic [W-1:0]    merged;
  logic [N-1:0]    ovf_flag;
  logic [EW-1:0]   ovf_count;

  ctrl_sync_merge #(.N_CTRL(N), .WORD_W(W), .CNT_W(CW), .ERR_W(EW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .op_valid_i(op_valid), .op_is_wait_i(op_is_wait), .op_word_i(op_word),
    .op_count_i(op_count), .op_ready_o(op_ready),
    .sig_valid_i(sig_valid), .sig_target_i(sig_target),
    .stall_o(stall), .release_o(release_s), .skip_o(skip),
    .merged_word_o(merged), .ovf_flag_o(ovf_flag), .ovf_count_o(ovf_count)
  );

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // ---------------- reference model, compared every cycle ----------------
  int m_act[N], m_wt[N], m_word[N], m_rem[N], m_pend[N], m_ovf[N];
  int m_err;
  int e_rdy[N], e_stall[N], e_rel[N], e_skip[N], e_take[N], e_done[N], e_left[N];
  int e_merged;

  always @(negedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        m_act[i] = 0; m_wt[i] = 0; m_word[i] = 0; m_rem[i] = 0; m_pend[i] = 0; m_ovf[i] = 0;
      end
      m_err = 0;
    end
    e_merged = 0;
    for (int i = 0; i < N; i++) begin
      int hits, avail, rel, last;
      hits = 0;
      for (int k = 0; k < N; k++)
        if (sig_valid[k] && int'(sig_target[k*IW +: IW]) == i) hits++;
      avail = m_pend[i] + hits;
      rel   = (m_act[i] && m_wt[i] && avail > 0) ? 1 : 0;
      avail = avail - rel;
      last  = (m_act[i] && !m_wt[i] && m_rem[i] == 1) ? 1 : 0;
      e_done[i]  = rel | last;
      e_rdy[i]   = (!m_act[i] || e_done[i]) ? 1 : 0;
      e_take[i]  = (op_valid[i] && e_rdy[i]) ? 1 : 0;
      e_skip[i]  = (e_take[i] && op_is_wait[i] && avail > 0) ? 1 : 0;
      e_left[i]  = avail - e_skip[i];
      e_rel[i]   = rel;
      e_stall[i] = (m_act[i] && m_wt[i] && !rel) ? 1 : 0;
      if (m_act[i]) e_merged = e_merged | m_word[i];
    end
    for (int i = 0; i < N; i++) begin
      check("R2", $sformatf("lane%0d ready", i), 64'(op_ready[i]), 64'(e_rdy[i]));
      check("R3", $sformatf("lane%0d stall", i), 64'(stall[i]), 64'(e_stall[i]));
      check("R4", $sformatf("lane%0d release", i), 64'(release_s[i]), 64'(e_rel[i]));
      check("R5", $sformatf("lane%0d skip", i), 64'(skip[i]), 64'(e_skip[i]));
      check("R7", $sformatf("lane%0d ovf flag", i), 64'(ovf_flag[i]), 64'(m_ovf[i]));
    end
    check("R8", "merged word", 64'(merged), 64'(e_merged));
    check("R7", "ovf count", 64'(ovf_count), 64'(m_err));
    if (rst_ni) begin
      for (int i = 0; i < N; i++) begin
        if (e_left[i] > 1) begin
          m_ovf[i] = 1;
          m_err = m_err + e_left[i] - 1;
          if (m_err > EMAX) m_err = EMAX;
        end
        m_pend[i] = (e_left[i] > 0) ? 1 : 0;
        if (e_take[i] && !e_skip[i]) begin
          m_act[i]  = 1;
          m_wt[i]   = op_is_wait[i];
          m_word[i] = int'(op_word[i*W +: W]);
          m_rem[i]  = (op_count[i*CW +: CW] == 0) ? 1 : int'(op_count[i*CW +: CW]);
        end else if (e_take[i] || e_done[i]) begin
          m_act[i] = 0;
        end else if (m_act[i] && !m_wt[i]) begin
          m_rem[i] = m_rem[i] - 1;
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clear_inputs();
    op_valid = '0; op_is_wait = '0; op_word = '0; op_count = '0;
    sig_valid = '0; sig_target = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1ns;
    clear_inputs();
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic put_op(input int lane, input bit wt, input int word, input int cnt);
    op_valid[lane] = 1'b1;
    op_is_wait[lane] = wt;
    op_word[lane*W +: W] = W'(word);
    op_count[lane*CW +: CW] = CW'(cnt);
  endtask

  task automatic put_sig(input int src, input int tgt);
    sig_valid[src] = 1'b1;
    sig_target[src*IW +: IW] = IW'(tgt);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  // ---------------- directed scenarios, then random traffic ----------------
  initial begin
    clear_inputs();
    repeat (3) at_neg();
    // R1: reset state
    check("R1", "ready in reset", 64'(op_ready), 64'hF);
    check("R1", "merged in reset", 64'(merged), 64'h0);
    check("R1", "ovf count in reset", 64'(ovf_count), 64'h0);
    @(posedge clk); #1ns; rst_ni = 1'b1;
    at_neg();
    check("R1", "stall after reset", 64'(stall), 64'h0);
    check("R1", "ovf flag after reset", 64'(ovf_flag), 64'h0);

    // R2: repeat of 3 cycles on lane 0
    tick(); put_op(0, 1'b0, 16'h0011, 3);
    tick(); at_neg();
    check("R2", "repeat cycle 1 word", 64'(merged), 64'h0011);
    check("R2", "repeat cycle 1 ready", 64'(op_ready[0]), 64'h0);
    tick(); at_neg();
    check("R2", "repeat cycle 2 word", 64'(merged), 64'h0011);
    tick(); at_neg();
    check("R2", "repeat cycle 3 ready", 64'(op_ready[0]), 64'h1);
    tick(); at_neg();
    check("R2", "repeat done word", 64'(merged), 64'h0);

    // R3/R4: late signal releases a waiting lane
    tick(); put_op(1, 1'b1, 16'h0100, 0);
    tick(); at_neg();
    check("R3", "wait stalls", 64'(stall[1]), 64'h1);
    check("R3", "wait word", 64'(merged), 64'h0100);
    tick(); at_neg();
    check("R3", "still stalled", 64'(stall[1]), 64'h1);
    tick(); put_sig(2, 1); at_neg();
    check("R4", "release pulse", 64'(release_s[1]), 64'h1);
    check("R4", "word in release cycle", 64'(merged), 64'h0100);
    check("R4", "ready in release cycle", 64'(op_ready[1]), 64'h1);
    tick(); at_neg();
    check("R4", "word after release", 64'(merged), 64'h0);

    // R5: early signal makes the next wait skip
    tick(); put_sig(3, 2); at_neg();
    check("R5", "no release while idle", 64'(release_s[2]), 64'h0);
    tick(); put_op(2, 1'b1, 16'h2000, 0); at_neg();
    check("R5", "skip pulse", 64'(skip[2]), 64'h1);
    tick(); at_neg();
    check("R5", "no stall after skip", 64'(stall[2]), 64'h0);
    check("R5", "no word after skip", 64'(merged), 64'h0);

    // R6: two controllers signal two targets in one cycle
    tick(); put_sig(0, 2); put_sig(1, 3);
    tick(); put_op(2, 1'b1, 16'h0002, 0); put_op(3, 1'b1, 16'h0003, 0); at_neg();
    check("R6", "both targets skip", 64'(skip[3:2]), 64'h3);
    tick(); at_neg();
    check("R6", "no stalls", 64'(stall), 64'h0);

    // R8: two repeats merge by OR
    tick(); put_op(0, 1'b0, 16'h00F0, 2); put_op(1, 1'b0, 16'h0F0F, 2);
    tick(); at_neg();
    check("R8", "OR of two lanes", 64'(merged), 64'h0FFF);
    tick(); at_neg();
    check("R8", "OR second cycle", 64'(merged), 64'h0FFF);
    tick(); at_neg();
    check("R8", "merged after repeats", 64'(merged), 64'h0);

    // R9: release and skip from two signals in one cycle
    tick(); put_op(1, 1'b1, 16'h0040, 0);
    tick(); at_neg();
    check("R9", "wait stalls first", 64'(stall[1]), 64'h1);
    tick(); put_sig(0, 1); put_sig(3, 1); put_op(1, 1'b1, 16'h0080, 0); at_neg();
    check("R9", "release used first", 64'(release_s[1]), 64'h1);
    check("R9", "second signal skips", 64'(skip[1]), 64'h1);
    tick(); at_neg();
    check("R9", "lane idle", 64'(merged), 64'h0);
    check("R9", "no drop", 64'(ovf_count), 64'h0);

    // R7: three signals at an idle lane drop two
    tick(); put_sig(0, 3); put_sig(1, 3); put_sig(2, 3);
    tick(); at_neg();
    check("R7", "flag set", 64'(ovf_flag), 64'h8);
    check("R7", "count of drops", 64'(ovf_count), 64'h2);
    tick(); put_op(3, 1'b1, 16'h0008, 0); at_neg();
    check("R7", "pending slot still skips", 64'(skip[3]), 64'h1);
    tick(); at_neg();
    check("R7", "flag sticky", 64'(ovf_flag[3]), 64'h1);

    // Random traffic against the model (all requirements)
    for (int c = 0; c < 3000; c++) begin
      tick();
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(2) == 0)
          put_op(i, ($urandom_range(3) == 0), int'($urandom_range(16'hFFFF)), int'($urandom_range(3)));
        if ($urandom_range(4) == 0)
          put_sig(i, int'($urandom_range(N - 1)));
      end
    end
    tick();
    repeat (2) at_neg();
    finish_run();
  end

endmodule